// File: doc/BRIEF.md
# Double-Buffered DAC Register Front End

This block is the digital front end of a 16-bit voltage-output converter. A host on a parallel bus writes a code word into an input latch while chip select and the write strobe are active, and can read the same latch back on a tri-state bus. The bus is split into an input word, an output word and an output-enable pin. A separate load strobe copies the input latch into the DAC latch, whose contents drive the converter code. Several converters can share one load line so that they all update together. If the load line is tied active, every write reaches the converter straight away.

A clear input forces both latches to one of two codes. The level on the read/write line picks the code: zero code for unipolar use, or midscale for bipolar use. Either way the analog output goes to 0 V. Each new load strobe starts a hold pulse of fixed length. This pulse freezes the output stage while the converter settles, so switching glitches stay hidden.

The block runs on one system clock. Every external strobe and the data word pass through two-flop synchronizers, so the host can drive them with no timing relation to that clock. All bus and control pins are plain level signals. There is no valid/ready handshake and no back-pressure: a write takes effect as long as the strobes stay low for at least three clock cycles.

Top module: `dual_latch_dac_if`

## Requirements
- R1: While reset is asserted and after it is released, `dac_code` is 0x0000, `bus_oe` is 0 and `hold_out` is 0, until the first strobe takes effect.
- R2: When `cs_n`=0 and `rnw`=0, the word on `bus_in` is stored in the input latch. Bit 0 is the LSB and bit 15 is the MSB.
- R3: When `cs_n`=0 and `rnw`=1, `bus_oe` is 1 and `bus_out` carries the input latch. When `cs_n`=1, `bus_oe` is 0 and `bus_out` is 0x0000.
- R4: While `load_n`=0, the DAC latch takes the input latch value on every clock. While `load_n`=1, `dac_code` holds its value unless a clear is active.
- R5: While `clr_n`=0 and `rnw`=0, both the DAC latch and the input latch are forced to 0x0000.
- R6: While `clr_n`=0 and `rnw`=1, both the DAC latch and the input latch are forced to 0x8000 (only bit 15 set).
- R7: A high-to-low transition of the synchronized `load_n` drives `hold_out` high for exactly HOLD_CYC clock cycles. HOLD_CYC = CLK_MHZ*HOLD_NS/1000, which is 312 at the default settings.
- R8: A new falling edge of `load_n` while `hold_out` is high restarts the hold count at HOLD_CYC.
- R9: When `load_n` is held low from reset onward, `hold_out` never goes high.
- R10: An active clear overrides a write and a load that happen at the same time.
- R11: A bus cycle with `cs_n`=1, or with `rnw`=1, leaves the input latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rnw | input | 1 | 1 = read back, 0 = write; also selects the clear code |
| load_n | input | 1 | Load strobe, active low, level transfer into the DAC latch |
| clr_n | input | 1 | Clear, active low |
| bus_in | input | 16 | Data word from the host bus |
| bus_out | output | 16 | Readback word, driven when bus_oe is 1 |
| bus_oe | output | 1 | Output enable for the external tri-state bus driver |
| dac_code | output | 16 | DAC latch contents sent to the converter |
| hold_out | output | 1 | Output-stage hold (deglitch) pulse |

## Verification
A strobe or data value applied before clock edge n is seen inside the block after edge n+1, once it has passed the two synchronizer flops. The input latch, the DAC latch and the start of the hold pulse therefore change after edge n+2, and `bus_oe` changes after edge n+1. The reference model in the bench keeps a history of past inputs. It updates its latches from the input two edges back, and it detects a load edge by comparing the values two and three edges back. The bench compares all outputs with this model on the falling clock edge of every cycle. The directed checks wait at least four cycles after a stimulus before sampling, so they never land on a cycle where the output is still changing. The hold window is checked at both ends of its 312-cycle length.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  // bit positions inside the synchronized strobe vector
  localparam int unsigned SIX_CS   = 0;
  localparam int unsigned SIX_RNW  = 1;
  localparam int unsigned SIX_CLR  = 2;
  localparam int unsigned SIX_LOAD = 3;
  localparam int unsigned STROBE_N = 4;

  // hold length in clock cycles from clock rate and wanted duration
  function automatic int unsigned hold_cycles(input int unsigned clk_mhz,
                                              input int unsigned hold_ns);
    return (clk_mhz * hold_ns) / 1000;
  endfunction
endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
  parameter int unsigned     N       = 4,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, safe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        safe_q <= RST_VAL[i];
      end else begin
        meta_q <= din[i];
        safe_q <= meta_q;
      end
    end
    assign dout[i] = safe_q;
  end
endmodule

// File: rtl/dac_latches.sv
module dac_latches #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         ld_en,
  input  logic         clr_en,
  input  logic         clr_mid,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] in_q,
  output logic [W-1:0] dac_q
);
  localparam logic [W-1:0] MID_CODE  = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ZERO_CODE = '0;

  logic [W-1:0] clr_val;
  assign clr_val = clr_mid ? MID_CODE : ZERO_CODE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else if (clr_en) begin
      in_q  <= clr_val;
      dac_q <= clr_val;
    end else begin
      if (wr_en) in_q  <= wr_data;
      if (ld_en) dac_q <= in_q;
    end
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !clr_mid) |=> (dac_q == '0 && in_q == '0)); // R5
  AST_CLR_MID: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_mid) |=> (dac_q == MID_CODE && in_q == MID_CODE)); // R6
  AST_DAC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && !ld_en) |=> $stable(dac_q)); // R4
  AST_INLAT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && !wr_en) |=> $stable(in_q)); // R11
  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && (wr_en || ld_en)) |=> (dac_q == in_q)); // R10
endmodule

// File: rtl/hold_timer.sv
module hold_timer #(
  parameter int unsigned HOLD_CYC = 312
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_act,
  output logic hold
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic          prev_act;
  logic          fire;
  logic [CW-1:0] cnt;

  // reset as "already active" so a load tied low never looks like an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_act <= 1'b1;
    else        prev_act <= ld_act;
  end

  assign fire = ld_act && !prev_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (fire)       cnt <= CW'(HOLD_CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign hold = (cnt != '0);

  AST_HOLD_START: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> hold); // R7
  AST_HOLD_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == CW'(HOLD_CYC))); // R8
  AST_HOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HOLD_CYC)); // R7
  AST_NO_EDGE_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && !fire) |=> !hold); // R9
endmodule

// File: rtl/dual_latch_dac_if.sv
module dual_latch_dac_if
  import dacif_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned CLK_MHZ = 125,
  parameter int unsigned HOLD_NS = 2500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              rnw,
  input  logic              load_n,
  input  logic              clr_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic [DATA_W-1:0] dac_code,
  output logic              hold_out
);
  localparam int unsigned HOLD_CYC = hold_cycles(CLK_MHZ, HOLD_NS);
  // cs, rnw, clear idle high; load resets low so a tied-low load is quiet
  localparam logic [STROBE_N-1:0] STROBE_RST = 4'b0111;

  logic [STROBE_N-1:0] strobe_raw, strobe_s;
  logic [DATA_W-1:0]   data_s;
  logic [DATA_W-1:0]   in_lat;
  logic                sel, rd, wr, ld, clr;

  assign strobe_raw[SIX_CS]   = cs_n;
  assign strobe_raw[SIX_RNW]  = rnw;
  assign strobe_raw[SIX_CLR]  = clr_n;
  assign strobe_raw[SIX_LOAD] = load_n;

  strobe_sync #(.N(STROBE_N), .RST_VAL(STROBE_RST)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n), .din(strobe_raw), .dout(strobe_s));

  // data goes through the same depth so it lines up with the strobes
  strobe_sync #(.N(DATA_W), .RST_VAL('0)) u_data_sync (
    .clk(clk), .rst_n(rst_n), .din(bus_in), .dout(data_s));

  assign sel = !strobe_s[SIX_CS];
  assign rd  = strobe_s[SIX_RNW];
  assign wr  = sel && !rd;
  assign ld  = !strobe_s[SIX_LOAD];
  assign clr = !strobe_s[SIX_CLR];

  dac_latches #(.W(DATA_W)) u_latches (
    .clk(clk), .rst_n(rst_n), .wr_en(wr), .ld_en(ld), .clr_en(clr),
    .clr_mid(rd), .wr_data(data_s), .in_q(in_lat), .dac_q(dac_code));

  hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .ld_act(ld), .hold(hold_out));

  assign bus_oe  = sel && rd;
  assign bus_out = bus_oe ? in_lat : '0;

  AST_RELEASED_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == '0)); // R3
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> (in_lat == $past(data_s))); // R2
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (dac_code == '0 && !hold_out && !bus_oe)); // R1
endmodule

// File: tb/test_dual_latch_dac_if.sv
`timescale 1ns/1ps
module test_dual_latch_dac_if;
  localparam int HOLD = 312;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rnw = 1'b1, load_n = 1'b1, clr_n = 1'b1;
  logic [15:0] bus_in = '0;
  logic [15:0] bus_out, dac_code;
  logic bus_oe, hold_out;

  always #4 clk = ~clk;

  dual_latch_dac_if i_dual_latch_dac_if (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rnw(rnw), .load_n(load_n),
    .clr_n(clr_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .dac_code(dac_code), .hold_out(hold_out));

  int total = 0, bad = 0;
  bit finished = 0;

  // ---------------- reference model ----------------
  logic h_cs[4], h_rnw[4], h_ld[4], h_clr[4];
  logic [15:0] h_d[4];
  logic [15:0] m_in, m_dac;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        h_cs[i] = 1; h_rnw[i] = 1; h_clr[i] = 1; h_ld[i] = 0; h_d[i] = '0;
      end
      m_in = '0; m_dac = '0; m_cnt = 0;
    end else begin
      // h[1] is the input two edges back, h[2] three edges back
      logic fire;
      fire = (h_ld[1] == 0) && (h_ld[2] == 1);
      if (h_clr[1] == 0) begin
        m_in  = h_rnw[1] ? 16'h8000 : 16'h0000;
        m_dac = m_in;
      end else begin
        logic [15:0] old_in;
        old_in = m_in;
        if (h_cs[1] == 0 && h_rnw[1] == 0) m_in = h_d[1];
        if (h_ld[1] == 0) m_dac = old_in;
      end
      if (fire) m_cnt = HOLD;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      for (int i = 3; i > 0; i--) begin
        h_cs[i] = h_cs[i-1]; h_rnw[i] = h_rnw[i-1]; h_ld[i] = h_ld[i-1];
        h_clr[i] = h_clr[i-1]; h_d[i] = h_d[i-1];
      end
      h_cs[0] = cs_n; h_rnw[0] = rnw; h_ld[0] = load_n; h_clr[0] = clr_n;
      h_d[0] = bus_in;
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic m_oe;
      m_oe = (h_cs[1] == 0) && (h_rnw[1] == 1);
      chk("R3 bus_oe", {15'd0, bus_oe}, {15'd0, m_oe});
      chk("R2 bus_out", bus_out, m_oe ? m_in : 16'h0000);
      chk("R4 dac_code", dac_code, m_dac);
      chk("R7 hold_out", {15'd0, hold_out}, {15'd0, m_cnt != 0});
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] d);
    cs_n = 0; rnw = 0; bus_in = d; wait_cyc(3);
    cs_n = 1; rnw = 1; wait_cyc(1);
  endtask

  task automatic read_back(input string tag, input logic [15:0] exp);
    cs_n = 0; rnw = 1; wait_cyc(4);
    chk(tag, bus_out, exp);
    chk(tag, {15'd0, bus_oe}, 16'd1);
    cs_n = 1; wait_cyc(1);
  endtask

  task automatic load_pulse();
    load_n = 0; wait_cyc(3); load_n = 1; wait_cyc(1);
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(5);
    chk("R1 dac_code in reset", dac_code, 16'h0000);
    chk("R1 hold in reset", {15'd0, hold_out}, 16'd0);
    rst_n = 1; wait_cyc(4);
    chk("R1 dac_code after reset", dac_code, 16'h0000);
    chk("R1 bus_oe after reset", {15'd0, bus_oe}, 16'd0);
    chk("R1 hold after reset", {15'd0, hold_out}, 16'd0);

    // write without load: DAC must not move
    bus_write(16'h1234); wait_cyc(3);
    read_back("R2 readback 1234", 16'h1234);
    chk("R4 dac held while load high", dac_code, 16'h0000);
    wait_cyc(3);
    chk("R3 bus released", {15'd0, bus_oe}, 16'd0);

    // load pulse and hold window
    load_pulse(); wait_cyc(3);
    chk("R4 dac after load", dac_code, 16'h1234);
    chk("R7 hold high after load", {15'd0, hold_out}, 16'd1);
    wait_cyc(HOLD);
    chk("R7 hold expired", {15'd0, hold_out}, 16'd0);

    // ignored bus cycles
    cs_n = 1; rnw = 0; bus_in = 16'hFFFF; wait_cyc(4);
    cs_n = 0; rnw = 1; bus_in = 16'hEEEE; wait_cyc(4); cs_n = 1; rnw = 1;
    wait_cyc(2);
    read_back("R11 latch unchanged", 16'h1234);

    // restart of hold count
    bus_write(16'h0001);
    load_pulse(); wait_cyc(100);
    load_pulse(); wait_cyc(250);
    chk("R8 hold restarted", {15'd0, hold_out}, 16'd1);
    wait_cyc(100);
    chk("R8 hold over after restart", {15'd0, hold_out}, 16'd0);
    chk("R2 LSB position", dac_code, 16'h0001);

    // clear to zero and to midscale
    rnw = 0; clr_n = 0; wait_cyc(3); clr_n = 1; rnw = 1; wait_cyc(3);
    chk("R5 clear zero dac", dac_code, 16'h0000);
    read_back("R5 clear zero latch", 16'h0000);
    bus_write(16'hABCD); load_pulse(); wait_cyc(3);
    chk("R4 dac ABCD", dac_code, 16'hABCD);
    rnw = 1; clr_n = 0; wait_cyc(3); clr_n = 1; wait_cyc(3);
    chk("R6 clear mid dac", dac_code, 16'h8000);
    read_back("R6 clear mid latch", 16'h8000);

    // clear together with write and load
    cs_n = 0; rnw = 0; bus_in = 16'h5555; load_n = 0; clr_n = 0; wait_cyc(5);
    chk("R10 clear beats write/load", dac_code, 16'h0000);
    clr_n = 1; cs_n = 1; rnw = 1; load_n = 1; wait_cyc(4);
    read_back("R10 latch holds clear code", 16'h0000);
    wait_cyc(HOLD + 4);

    // load tied low from reset
    rst_n = 0; load_n = 0; wait_cyc(3); rst_n = 1;
    for (int k = 0; k < 6; k++) begin
      bus_write(16'h1111 * k[15:0]);
      for (int j = 0; j < 6; j++) begin
        wait_cyc(1);
        chk("R9 no hold with load tied low", {15'd0, hold_out}, 16'd0);
      end
      chk("R4 transparent follow", dac_code, 16'h1111 * k[15:0]);
    end

    // mixed pattern phase
    load_n = 1; wait_cyc(HOLD + 4);
    for (int n = 0; n < 3000; n++) begin
      if (n % 3 == 0) begin
        int r;
        r = $urandom;
        cs_n = r[0] | r[1];
        rnw = r[2];
        load_n = (r[7:3] != 0);
        clr_n = (r[12:8] != 0);
        bus_in = 16'($urandom);
      end
      wait_cyc(1);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule